// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Signed-Overflow Trap

This block is the integer add/subtract stage of a small processor datapath. It takes two W-bit operands, an operation select choosing between addition and subtraction, and a mode bit that chooses signed or unsigned interpretation. The result and the carry-out are combinational. Subtraction does not use a separate subtractor. The second operand is bit-inverted and a carry-in of one goes into the same ripple adder. The carry-out for a subtraction is therefore the raw adder carry, where 1 means no borrow.

The bit pattern of the result does not depend on the mode. The mode only decides what happens on overflow. In unsigned mode the sum wraps modulo 2^W and nothing else occurs. In signed mode a two's-complement overflow has two effects:
- The destination write-enable is suppressed in the same cycle, so the wrapped value is never committed.
- A sticky trap request is raised on the next clock edge. It stays high until the handler acknowledges it.

Top module: `addsub_trap`

## Requirements
- R1: With `sub_i`=0, `result_o` equals (`a_i` + `b_i`) mod 2^W.
- R2: With `sub_i`=1, `result_o` equals (`a_i` - `b_i`) mod 2^W.
- R3: `carry_o` is the carry out of the top adder bit. For an add it is 1 exactly when `a_i`+`b_i` >= 2^W. For a subtract it is 1 exactly when `a_i` >= `b_i` as unsigned values, meaning no borrow.
- R4: With `signed_i`=0 and `valid_i`=1, `wr_en_o` is 1 and no trap is ever raised, whatever the carry.
- R5: Signed overflow is defined as follows. For an add, both operands have the same sign and the result sign differs from it. For a subtract, the operand signs differ and the result sign differs from the sign of `a_i`.
- R6: When `valid_i`=1, `signed_i`=1 and a signed overflow occurs, `wr_en_o` is 0 in that cycle and `trap_o` is 1 from the next rising clock edge on.
- R7: `trap_o` stays 1 until a rising edge at which `trap_ack_i` is 1. At that edge it clears, unless a new trap is set at the same edge.
- R8: If a new signed overflow and `trap_ack_i` occur at the same edge, the new trap wins and `trap_o` remains 1.
- R9: With `valid_i`=0, `wr_en_o` is 0 and no trap is set, even if the operands would overflow.
- R10: While `rst_ni` is 0, `trap_o` is 0.
- R11: `result_o` and `carry_o` are identical in signed and unsigned mode for the same operands and operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An operation is presented this cycle |
| sub_i | input | 1 | 0 = add, 1 = subtract |
| signed_i | input | 1 | 1 = signed mode (overflow traps), 0 = unsigned (wraps) |
| a_i | input | W | First operand (minuend for subtract) |
| b_i | input | W | Second operand (subtrahend for subtract) |
| trap_ack_i | input | 1 | Handler acknowledge, clears the trap request |
| result_o | output | W | Sum or difference modulo 2^W |
| carry_o | output | 1 | Carry out of the top bit (1 = no borrow on subtract) |
| wr_en_o | output | 1 | Destination write-enable, suppressed on signed overflow |
| trap_o | output | 1 | Sticky overflow trap request |

## Verification
The hardest situation to reach is an acknowledge that arrives at the same edge as a fresh signed overflow. Exercising it needs a trap already pending, then a single cycle that carries both the handler's acknowledge and new overflowing operands. The stimulus builds this deliberately. It raises a trap, holds it for several idle cycles, and then drives the acknowledge together with a subtract that overflows. Subtracts whose subtrahend is the most negative value are also aimed at specifically, because the inverted operand's sign flips there.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int unsigned ADDSUB_W = 32;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } addsub_op_e;
endpackage

// File: rtl/addsub_prep.sv
module addsub_prep #(
  parameter int unsigned W = addsub_pkg::ADDSUB_W
) (
  input  logic         sub_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_eff_o,
  output logic         cin_o
);
  import addsub_pkg::*;

  addsub_op_e op;
  assign op = addsub_op_e'(sub_i);

  for (genvar i = 0; i < W; i++) begin : g_inv
    assign b_eff_o[i] = b_i[i] ^ (op == OP_SUB);
  end

  assign cin_o = (op == OP_SUB);
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
  parameter int unsigned W = addsub_pkg::ADDSUB_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] c;

  assign c[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic p;
    assign p        = a_i[i] ^ b_i[i];
    assign sum_o[i] = p ^ c[i];
    assign c[i+1]   = (a_i[i] & b_i[i]) | (p & c[i]);
  end

  assign cout_o = c[W];
endmodule

// File: rtl/addsub_ovf.sv
module addsub_ovf (
  input  logic signed_i,
  input  logic a_msb_i,
  input  logic b_eff_msb_i,
  input  logic sum_msb_i,
  output logic ovf_o
);
  logic same_sign;

  // Inputs to the top adder bit agree, but the result sign disagrees.
  assign same_sign = ~(a_msb_i ^ b_eff_msb_i);
  assign ovf_o     = signed_i & same_sign & (sum_msb_i ^ a_msb_i);
endmodule

// File: rtl/addsub_trap_ctl.sv
module addsub_trap_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  output logic trap_o
);
  logic trap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     trap_q <= 1'b0;
    else if (set_i)  trap_q <= 1'b1;   // new trap beats ack
    else if (ack_i)  trap_q <= 1'b0;
  end

  assign trap_o = trap_q;
endmodule

// File: rtl/addsub_trap.sv
module addsub_trap #(
  parameter int unsigned W = addsub_pkg::ADDSUB_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         sub_i,
  input  logic         signed_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         trap_ack_i,
  output logic [W-1:0] result_o,
  output logic         carry_o,
  output logic         wr_en_o,
  output logic         trap_o
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] b_eff;
  logic         cin;
  logic [W-1:0] sum;
  logic         ovf;
  logic         trap_set;

  addsub_prep #(.W(W)) u_prep (
    .sub_i   (sub_i),
    .b_i     (b_i),
    .b_eff_o (b_eff),
    .cin_o   (cin)
  );

  addsub_ripple #(.W(W)) u_add (
    .a_i    (a_i),
    .b_i    (b_eff),
    .cin_i  (cin),
    .sum_o  (sum),
    .cout_o (carry_o)
  );

  addsub_ovf u_ovf (
    .signed_i    (signed_i),
    .a_msb_i     (a_i[MSB]),
    .b_eff_msb_i (b_eff[MSB]),
    .sum_msb_i   (sum[MSB]),
    .ovf_o       (ovf)
  );

  assign trap_set = valid_i & ovf;
  assign result_o = sum;
  assign wr_en_o  = valid_i & ~ovf;

  addsub_trap_ctl u_trap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (trap_set),
    .ack_i  (trap_ack_i),
    .trap_o (trap_o)
  );
endmodule

// File: rtl/addsub_trap_chk.sv
module addsub_trap_chk #(
  parameter int unsigned W = addsub_pkg::ADDSUB_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic         sub_i,
  input logic         signed_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         trap_ack_i,
  input logic [W-1:0] result_o,
  input logic         carry_o,
  input logic         wr_en_o,
  input logic         trap_o
);
  logic [W:0] wide_sum;
  logic       s_ovf;

  assign wide_sum = sub_i ? ({1'b0, a_i} + {1'b0, ~b_i} + (W+1)'(1))
                          : ({1'b0, a_i} + {1'b0, b_i});

  assign s_ovf = sub_i ? ((a_i[W-1] != b_i[W-1]) && (wide_sum[W-1] != a_i[W-1]))
                       : ((a_i[W-1] == b_i[W-1]) && (wide_sum[W-1] != a_i[W-1]));

  AST_RESULT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> result_o == wide_sum[W-1:0]);                          // R1
  AST_CARRY_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> carry_o == wide_sum[W]);                               // R3
  AST_UNSIGNED_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !signed_i) |-> wr_en_o);                               // R4
  AST_SIGNED_OVF_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && signed_i) |-> (wr_en_o == !s_ovf));                    // R5
  AST_TRAP_RAISED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && signed_i && !wr_en_o) |=> trap_o);                     // R6
  AST_TRAP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && !trap_ack_i) |=> trap_o);                               // R7
  AST_TRAP_ACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && trap_ack_i && !(valid_i && signed_i && s_ovf)) |=> !trap_o); // R7
  AST_TRAP_ACK_LOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_ack_i && valid_i && signed_i && s_ovf) |=> trap_o);          // R8
  AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !wr_en_o);                                            // R9
  AST_IDLE_NO_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !trap_o) |=> !trap_o);                                // R9
endmodule

bind addsub_trap addsub_trap_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .sub_i      (sub_i),
  .signed_i   (signed_i),
  .a_i        (a_i),
  .b_i        (b_i),
  .trap_ack_i (trap_ack_i),
  .result_o   (result_o),
  .carry_o    (carry_o),
  .wr_en_o    (wr_en_o),
  .trap_o     (trap_o)
);

// File: tb/tb_addsub_trap.sv
module tb_addsub_trap;
  localparam int unsigned W = 32;
  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0, sub = 1'b0, sgn = 1'b0, ack = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [W-1:0] result;
  logic carry, wr_en, trap;

  int checks = 0;
  int fails = 0;
  logic model_trap = 1'b0;

  typedef struct {
    logic [W-1:0] res;
    logic         cy;
    logic         wr;
    logic         tr;
    string        tag;
    logic         is_sub;
  } exp_t;

  exp_t sb_q[$];

  always #2.5 clk = ~clk;   // 200 MHz

  addsub_trap #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .sub_i(sub), .signed_i(sgn),
    .a_i(a), .b_i(b), .trap_ack_i(ack),
    .result_o(result), .carry_o(carry), .wr_en_o(wr_en), .trap_o(trap)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h @%0t", req, act, exp, $time);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected outputs.
  task automatic step(input logic [W-1:0] ta, input logic [W-1:0] tb,
                      input logic ts, input logic tsg, input logic tv,
                      input logic tk, input string tag);
    exp_t e;
    logic [W:0] u;
    logic signed [W:0] s;
    logic ovf;
    @(negedge clk);
    a = ta; b = tb; sub = ts; sgn = tsg; valid = tv; ack = tk;
    if (ts) begin
      u = {1'b0, ta} + {1'b0, ~tb} + (W+1)'(1);
      s = $signed({ta[W-1], ta}) - $signed({tb[W-1], tb});
    end else begin
      u = {1'b0, ta} + {1'b0, tb};
      s = $signed({ta[W-1], ta}) + $signed({tb[W-1], tb});
    end
    ovf = tsg && (s[W] != s[W-1]);
    e.res = u[W-1:0];
    e.cy  = u[W];
    e.wr  = tv && !ovf;
    e.tr  = model_trap;
    e.tag = tag;
    e.is_sub = ts;
    sb_q.push_back(e);
    if (tv && ovf)  model_trap = 1'b1;
    else if (tk)    model_trap = 1'b0;
  endtask

  task automatic idle(input int n, input logic tk);
    for (int i = 0; i < n; i++) step('0, '0, 1'b0, 1'b0, 1'b0, tk, "R7/R9 idle");
  endtask

  // Monitor: pops expected items and compares mid-cycle.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #1.5;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        chk(e.is_sub ? {"R2 result ", e.tag} : {"R1 result ", e.tag}, result, e.res);
        chk({"R3 carry ", e.tag}, W'(carry), W'(e.cy));
        chk({"R4/R6/R9 wr_en ", e.tag}, W'(wr_en), W'(e.wr));
        chk({"R6/R7/R8 trap ", e.tag}, W'(trap), W'(e.tr));
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    // R10: trap held low in reset even with overflowing inputs
    valid = 1'b1; sgn = 1'b1; a = MAXP; b = 32'd1;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset trap", W'(trap), W'(0));
    @(negedge clk);
    valid = 1'b0;
    rst_n = 1'b1;

    // R1/R3/R4/R11: unsigned add and carry
    step(32'd7, 32'd9, 1'b0, 1'b0, 1'b1, 1'b0, "R1 small add");
    step(ONES, 32'd1, 1'b0, 1'b0, 1'b1, 1'b0, "R3 R4 unsigned wrap");
    step(MAXP, 32'd1, 1'b0, 1'b0, 1'b1, 1'b0, "R4 R11 unsigned no trap");
    // R2/R3: subtract, borrow reporting
    step(32'd5, 32'd3, 1'b1, 1'b0, 1'b1, 1'b0, "R2 R3 no borrow");
    step(32'd3, 32'd5, 1'b1, 1'b0, 1'b1, 1'b0, "R2 R3 borrow");
    step(32'd4, 32'd4, 1'b1, 1'b1, 1'b1, 1'b0, "R3 equal operands");
    step(MINN, 32'd1, 1'b1, 1'b0, 1'b1, 1'b0, "R4 R11 unsigned sub wrap");
    // R9: valid low with overflowing operands
    step(MAXP, 32'd1, 1'b0, 1'b1, 1'b0, 1'b0, "R9 invalid overflow");
    idle(2, 1'b0);
    // R5/R6: signed positive overflow
    step(MAXP, 32'd1, 1'b0, 1'b1, 1'b1, 1'b0, "R5 R6 pos add overflow");
    idle(4, 1'b0);                                     // R7 hold
    step(32'd1, 32'd2, 1'b0, 1'b1, 1'b1, 1'b0, "R7 clean op while pending");
    idle(1, 1'b1);                                     // R7 ack
    idle(2, 1'b0);
    // R5: negative add overflow, signed no-overflow cases
    step(MINN, MINN, 1'b0, 1'b1, 1'b1, 1'b0, "R5 neg add overflow");
    step(ONES, 32'd3, 1'b0, 1'b1, 1'b1, 1'b1, "R5 signed -1+3 no ovf ack");
    step(MINN, 32'd1, 1'b1, 1'b1, 1'b1, 1'b0, "R5 min-1 overflow");
    idle(2, 1'b0);
    // R8: ack coincides with new overflow
    step(32'd0, MINN, 1'b1, 1'b1, 1'b1, 1'b1, "R8 ack with 0-min overflow");
    idle(2, 1'b0);
    idle(1, 1'b1);
    step(ONES, MINN, 1'b1, 1'b1, 1'b1, 1'b0, "R5 -1-min no overflow");
    step(MAXP, ONES, 1'b1, 1'b1, 1'b1, 1'b0, "R5 max-(-1) overflow");
    idle(1, 1'b1);

    // Mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] ra, rb;
      logic [3:0] sel;
      ra = $urandom(); rb = $urandom(); sel = 4'($urandom());
      if (sel[3:2] == 2'b00) ra = sel[0] ? MAXP : MINN;
      step(ra, rb, sel[0], sel[1], (sel != 4'hF), (sel[2] & sel[3]), "mixed");
    end
    idle(2, 1'b1);

    wait (sb_q.size() == 0);
    @(negedge clk);
    #2;
    summary();
    $finish;
  end
endmodule